// File: doc/BRIEF.md
# Biased-Branch Filter Beside a Set-Associative Target Buffer

This block sits next to a global-history direction predictor and picks out the branches that always go the same way. Every tracked branch owns a small record in a set-associative buffer: a tag, a stored direction and a short run counter that counts outcomes agreeing with that direction. Once a branch has resolved the same way eight times in a row, the filter predicts it from the stored direction. The main predictor is then neither consulted nor trained for it, which keeps its tables free of branches that carry no history information.

The front end presents a fetch address on the lookup port. One cycle later the filter reports whether the branch is tracked, whether its bias is trusted, and the trusted direction. When a branch resolves, the back end presents its address, its actual direction and whether the bias path made its prediction. The filter then trains its own record and tells the main predictor, in the same cycle, whether that predictor should train. When the bias path made a correct prediction, nothing changes anywhere.

Top module: `bias_filter`

## Requirements
- R1: The set index is address bits [8:2] and the tag is address bits [31:9] (default sizes: 512 records, 4 ways, 128 sets). A lookup result appears on the cycle after `lk_valid`. With `lk_valid` low, all three lookup outputs read 0 on the next cycle.
- R2: A resolved branch that misses in the buffer is given a record holding the resolved direction and a run count of 0. A later lookup hits, with `lk_bias_vld` low and `lk_bias_dir` equal to that direction.
- R3: An outcome equal to the stored direction raises the run count by one, and the count saturates at 7. `lk_bias_vld` is high exactly when the hit record's count is 7, so the eighth identical outcome since allocation or since the last direction change makes the bias trusted.
- R4: An outcome that differs from the stored direction replaces the direction with the outcome and clears the run count to 0.
- R5: An update with `up_bias_used` high whose outcome equals the stored direction changes nothing: not the record, and not the replacement order.
- R6: On allocation, the lowest-numbered empty way of the set is filled first. Otherwise the way least recently written by an update is replaced. Lookups do not change the replacement order.
- R7: `up_main_en` is high in the same cycle exactly when `up_valid` is high and `up_bias_used` is low.
- R8: After reset the buffer is empty: every lookup misses and the lookup outputs read 0.
- R9: A lookup and an update in the same cycle: the lookup reports the buffer contents from before that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Lookup branch address |
| lk_hit | output | 1 | Branch tracked (one cycle after request) |
| lk_bias_vld | output | 1 | Stored bias is trusted |
| lk_bias_dir | output | 1 | Stored direction, 1 = taken |
| up_valid | input | 1 | Resolved-branch update |
| up_pc | input | 32 | Resolved branch address |
| up_taken | input | 1 | Actual direction, 1 = taken |
| up_bias_used | input | 1 | The bias path made this branch's prediction |
| up_main_en | output | 1 | Main predictor should train on this update |

## Verification
The directed part drives one branch through allocation, seven agreeing outcomes, the eighth outcome that trusts the bias, a correct bias-path update and a direction flip. Each step separates the count threshold from the off-by-one alternatives, and separates a frozen record from a trained one. A second pattern packs five tags into one set with an interleaved refresh and a lookup. Which tag gets evicted then shows whether replacement follows update recency, and not lookup recency or way order. A long randomized stream over a small address pool, with a behavioural queue model compared every clock, mixes same-cycle lookups and updates, flips and evictions.

// File: rtl/bf_pkg.sv
package bf_pkg;

    localparam int CNT_W = 3;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        UPD_IDLE,
        UPD_ALLOC,
        UPD_KEEP,
        UPD_STRENGTHEN,
        UPD_FLIP
    } upd_kind_e;

    function automatic logic cnt_full(input cnt_t c);
        return &c;
    endfunction

    function automatic cnt_t cnt_bump(input cnt_t c);
        return cnt_full(c) ? c : c + cnt_t'(1);
    endfunction

endpackage

// File: rtl/bf_set_match.sv
module bf_set_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            way
);
    logic [WAYS-1:0] match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = vld[w] && (tags[w] == tag);
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit = 1'b1;
                way = WAY_W'(w);
            end
        end
    end

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R6

endmodule

// File: rtl/bf_lru.sv
module bf_lru #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WAYS-1:0][WAY_W-1:0]  ages,
    input  logic [WAYS-1:0]             vld,
    input  logic                        touch,
    input  logic [WAY_W-1:0]            touch_way,
    output logic [WAY_W-1:0]            victim,
    output logic [WAYS-1:0][WAY_W-1:0]  ages_nxt
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic            any_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] old_way;
    logic [WAYS-1:0] zero_age;

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        old_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
            if (ages[w] == OLDEST) begin
                old_way = WAY_W'(w);
            end
        end
        victim = any_free ? free_way : old_way;
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_age
            always_comb begin
                if (!touch) begin
                    ages_nxt[w] = ages[w];
                end else if (WAY_W'(w) == touch_way) begin
                    ages_nxt[w] = '0;
                end else if (ages[w] < ages[touch_way]) begin
                    ages_nxt[w] = ages[w] + WAY_W'(1);
                end else begin
                    ages_nxt[w] = ages[w];
                end
            end
            assign zero_age[w] = (ages_nxt[w] == '0);
        end
    endgenerate

    AST_LRU_MRU: assert property (@(posedge clk) disable iff (rst)
        touch |-> ($countones(zero_age) == 1) && zero_age[touch_way]); // R6

endmodule

// File: rtl/bias_filter.sv
module bias_filter
    import bf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 512,
    parameter int WAYS    = 4,
    parameter int OFS_W   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_bias_vld,
    output logic            lk_bias_dir,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic            up_bias_used,
    output logic            up_main_en
);
    localparam int SETS  = ENTRIES / WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = PC_W - OFS_W - IDX_W;
    localparam int NPORT = 2;   // port 0 = lookup, port 1 = update

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic             bias;
        cnt_t             cnt;
    } entry_t;

    entry_t           tbl [SETS][WAYS];
    logic [WAY_W-1:0] age [SETS][WAYS];

    // ---------------- address split and per-port tag match ----------------
    logic [NPORT-1:0][PC_W-1:0]  p_pc;
    logic [NPORT-1:0][IDX_W-1:0] p_idx;
    logic [NPORT-1:0][TAG_W-1:0] p_tag;
    logic [NPORT-1:0]            p_hit;
    logic [NPORT-1:0][WAY_W-1:0] p_way;

    assign p_pc[0] = lk_pc;
    assign p_pc[1] = up_pc;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            logic [WAYS-1:0]            set_vld;
            logic [WAYS-1:0][TAG_W-1:0] set_tag;

            assign p_idx[p] = p_pc[p][OFS_W +: IDX_W];
            assign p_tag[p] = p_pc[p][PC_W-1 -: TAG_W];

            for (genvar w = 0; w < WAYS; w++) begin : g_way
                assign set_vld[w] = tbl[p_idx[p]][w].vld;
                assign set_tag[w] = tbl[p_idx[p]][w].tag;
            end

            bf_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
                .clk  (clk),
                .rst  (rst),
                .vld  (set_vld),
                .tags (set_tag),
                .tag  (p_tag[p]),
                .hit  (p_hit[p]),
                .way  (p_way[p])
            );
        end
    endgenerate

    // ---------------- lookup path ----------------
    entry_t lk_e;
    assign lk_e = tbl[p_idx[0]][p_way[0]];

    // ---------------- update path ----------------
    entry_t                     up_e;
    entry_t                     new_e;
    upd_kind_e                  kind;
    logic                       touch;
    logic [WAY_W-1:0]           victim;
    logic [WAY_W-1:0]           wr_way;
    logic [WAYS-1:0][WAY_W-1:0] set_age;
    logic [WAYS-1:0][WAY_W-1:0] set_age_nxt;
    logic [WAYS-1:0]            up_set_vld;

    assign up_e = tbl[p_idx[1]][p_way[1]];

    always_comb begin
        if (!up_valid) begin
            kind = UPD_IDLE;
        end else if (!p_hit[1]) begin
            kind = UPD_ALLOC;
        end else if (up_bias_used && (up_e.bias == up_taken)) begin
            kind = UPD_KEEP;
        end else if (up_e.bias != up_taken) begin
            kind = UPD_FLIP;
        end else begin
            kind = UPD_STRENGTHEN;
        end
    end

    always_comb begin
        new_e = up_e;
        unique case (kind)
            UPD_ALLOC: begin
                new_e.vld  = 1'b1;
                new_e.tag  = p_tag[1];
                new_e.bias = up_taken;
                new_e.cnt  = '0;
            end
            UPD_FLIP: begin
                new_e.bias = up_taken;
                new_e.cnt  = '0;
            end
            UPD_STRENGTHEN: new_e.cnt = cnt_bump(up_e.cnt);
            default: new_e = up_e;
        endcase
    end

    assign touch  = (kind == UPD_ALLOC) || (kind == UPD_FLIP) || (kind == UPD_STRENGTHEN);
    assign wr_way = (kind == UPD_ALLOC) ? victim : p_way[1];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_upset
            assign set_age[w]    = age[p_idx[1]][w];
            assign up_set_vld[w] = tbl[p_idx[1]][w].vld;
        end
    endgenerate

    bf_lru #(.WAYS(WAYS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .ages      (set_age),
        .vld       (up_set_vld),
        .touch     (touch),
        .touch_way (wr_way),
        .victim    (victim),
        .ages_nxt  (set_age_nxt)
    );

    assign up_main_en = up_valid && !up_bias_used;

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tbl[s][w] <= '0;
                    age[s][w] <= WAY_W'(w);
                end
            end
            lk_hit      <= 1'b0;
            lk_bias_vld <= 1'b0;
            lk_bias_dir <= 1'b0;
        end else begin
            lk_hit      <= lk_valid && p_hit[0];
            lk_bias_vld <= lk_valid && p_hit[0] && cnt_full(lk_e.cnt);
            lk_bias_dir <= lk_valid && p_hit[0] && lk_e.bias;
            if (touch) begin
                tbl[p_idx[1]][wr_way] <= new_e;
                for (int w = 0; w < WAYS; w++) begin
                    age[p_idx[1]][w] <= set_age_nxt[w];
                end
            end
        end
    end

    AST_LK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_hit && !lk_bias_vld && !lk_bias_dir); // R1

    AST_BIAS_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        lk_bias_vld |-> lk_hit); // R3

    AST_MAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (kind == UPD_KEEP) |-> !up_main_en); // R5

endmodule

// File: tb/bias_filter_test.sv
module bias_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS      = 128;
    localparam int NWAYS      = 4;
    localparam int SAT        = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit, lk_bias_vld, lk_bias_dir;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic        up_bias_used = 1'b0;
    logic        up_main_en;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R8";

    bias_filter uut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_hit(lk_hit), .lk_bias_vld(lk_bias_vld), .lk_bias_dir(lk_bias_dir),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_bias_used(up_bias_used), .up_main_en(up_main_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural model: per set, records ordered most recent first ----------------
    typedef struct {
        int tag;
        bit bias;
        int cnt;
    } rec_t;

    rec_t q [NSETS][$];
    bit e_hit = 0, e_bv = 0, e_bd = 0;

    function automatic int set_of(input logic [31:0] pc);
        return int'(pc[8:2]);
    endfunction

    function automatic int tag_of(input logic [31:0] pc);
        return int'(pc[31:9]);
    endfunction

    function automatic int find(input int s, input int t);
        for (int i = 0; i < q[s].size(); i++) if (q[s][i].tag == t) return i;
        return -1;
    endfunction

    function automatic bit model_sat(input logic [31:0] pc);
        int f;
        f = find(set_of(pc), tag_of(pc));
        return (f >= 0) && (q[set_of(pc)][f].cnt == SAT);
    endfunction

    always @(posedge clk) begin
        int s, t, f;
        rec_t r;
        if (rst) begin
            for (int i = 0; i < NSETS; i++) q[i].delete();
            e_hit = 0; e_bv = 0; e_bd = 0;
        end else begin
            e_hit = 0; e_bv = 0; e_bd = 0;
            if (lk_valid) begin
                s = set_of(lk_pc); t = tag_of(lk_pc); f = find(s, t);
                if (f >= 0) begin
                    e_hit = 1; e_bv = (q[s][f].cnt == SAT); e_bd = q[s][f].bias;
                end
            end
            if (up_valid) begin
                s = set_of(up_pc); t = tag_of(up_pc); f = find(s, t);
                if (f < 0) begin
                    if (q[s].size() == NWAYS) void'(q[s].pop_back());
                    r.tag = t; r.bias = up_taken; r.cnt = 0;
                    q[s].push_front(r);
                end else if (!(up_bias_used && q[s][f].bias == up_taken)) begin
                    r = q[s][f];
                    if (r.bias != up_taken) begin
                        r.bias = up_taken; r.cnt = 0;
                    end else if (r.cnt < SAT) begin
                        r.cnt++;
                    end
                    q[s].delete(f);
                    q[s].push_front(r);
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        check(lk_hit == e_hit, cur_req, "lk_hit", lk_hit, e_hit);
        check(lk_bias_vld == e_bv, cur_req, "lk_bias_vld", lk_bias_vld, e_bv);
        check(lk_bias_dir == e_bd, cur_req, "lk_bias_dir", lk_bias_dir, e_bd);
    endtask

    // drive at negedge, check main enable, clock, then compare registered outputs
    task automatic step(input bit lv, input logic [31:0] lp,
                        input bit uv, input logic [31:0] upc, input bit tk, input bit used);
        lk_valid = lv; lk_pc = lp;
        up_valid = uv; up_pc = upc; up_taken = tk; up_bias_used = used;
        #1;
        check(up_main_en == (uv && !used), "R7", "up_main_en", up_main_en, uv && !used);
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic look(input logic [31:0] pc);
        step(1, pc, 0, 32'h0, 0, 0);
    endtask

    task automatic upd(input logic [31:0] pc, input bit tk, input bit used);
        step(0, 32'h0, 1, pc, tk, used);
    endtask

    function automatic logic [31:0] mk_pc(input int t, input int s);
        return (32'(t) << 9) | (32'(s) << 2);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        logic [31:0] pool [12];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: empty after reset
        check(lk_hit == 0 && lk_bias_vld == 0 && lk_bias_dir == 0, "R8", "outputs after reset",
              {lk_hit, lk_bias_vld, lk_bias_dir}, 0);
        cur_req = "R8";
        look(mk_pc(3, 10));
        check(lk_hit == 0, "R8", "lookup after reset", lk_hit, 0);

        // R1: idle lookup reads zero
        cur_req = "R1";
        step(0, mk_pc(3, 10), 0, 32'h0, 0, 0);
        check(lk_hit == 0, "R1", "idle lookup", lk_hit, 0);

        // R2: allocate on miss
        cur_req = "R2";
        a = mk_pc(17, 20);
        upd(a, 1, 0);
        look(a);
        check(lk_hit == 1 && lk_bias_vld == 0 && lk_bias_dir == 1, "R2", "fresh record",
              {lk_hit, lk_bias_vld, lk_bias_dir}, 3'b101);
        // R1: same index, other tag, misses
        cur_req = "R1";
        look(mk_pc(18, 20));
        check(lk_hit == 0, "R1", "tag compare", lk_hit, 0);

        // R3: seven agreeing outcomes total -> not yet trusted, eighth -> trusted
        cur_req = "R3";
        for (int i = 0; i < 6; i++) upd(a, 1, 0);
        look(a);
        check(lk_bias_vld == 0, "R3", "seven outcomes", lk_bias_vld, 0);
        upd(a, 1, 0);
        look(a);
        check(lk_bias_vld == 1 && lk_bias_dir == 1, "R3", "eight outcomes", {lk_bias_vld, lk_bias_dir}, 3);
        upd(a, 1, 0);
        look(a);
        check(lk_bias_vld == 1, "R3", "saturated stays", lk_bias_vld, 1);

        // R5: correct bias-path update changes nothing
        cur_req = "R5";
        upd(a, 1, 1);
        look(a);
        check(lk_bias_vld == 1 && lk_bias_dir == 1, "R5", "record kept", {lk_bias_vld, lk_bias_dir}, 3);

        // R4: disagreeing outcome flips and clears
        cur_req = "R4";
        upd(a, 0, 1);
        look(a);
        check(lk_hit == 1 && lk_bias_vld == 0 && lk_bias_dir == 0, "R4", "flip",
              {lk_hit, lk_bias_vld, lk_bias_dir}, 3'b100);

        // R6: replacement order in set 5
        cur_req = "R6";
        for (int t = 1; t <= 4; t++) upd(mk_pc(t, 5), t[0], 0);
        upd(mk_pc(1, 5), 1, 0);    // refresh tag 1
        look(mk_pc(2, 5));          // lookup must not refresh tag 2
        upd(mk_pc(5, 5), 0, 0);    // evicts tag 2
        look(mk_pc(2, 5));
        check(lk_hit == 0, "R6", "oldest evicted", lk_hit, 0);
        look(mk_pc(1, 5));
        check(lk_hit == 1, "R6", "refreshed kept", lk_hit, 1);
        look(mk_pc(3, 5));
        check(lk_hit == 1, "R6", "newer kept", lk_hit, 1);

        // R5: a kept update does not refresh recency
        for (int i = 0; i < 8; i++) upd(mk_pc(3, 5), 1, 0);
        upd(mk_pc(3, 5), 1, 1);    // kept: tag 3 not refreshed
        upd(mk_pc(4, 5), 0, 0);
        upd(mk_pc(1, 5), 1, 0);
        upd(mk_pc(5, 5), 0, 0);
        upd(mk_pc(6, 5), 1, 0);    // evicts oldest update: tag 3
        look(mk_pc(3, 5));
        check(lk_hit == 0, "R5", "kept update left order", lk_hit, 0);

        // R9: same-cycle lookup and allocation
        cur_req = "R9";
        b = mk_pc(40, 77);
        step(1, b, 1, b, 1, 0);
        check(lk_hit == 0, "R9", "lookup sees old state", lk_hit, 0);
        look(b);
        check(lk_hit == 1, "R9", "visible next", lk_hit, 1);

        // randomized stream over a small pool
        cur_req = "R3";
        for (int i = 0; i < 12; i++) pool[i] = mk_pc(i % 6 + 1, (i < 6) ? 9 : 33);
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] lp, upc;
            bit uv, used, tk;
            lp  = pool[$urandom_range(0, 11)];
            upc = pool[$urandom_range(0, 11)];
            uv  = ($urandom_range(0, 3) != 0);
            tk  = ($urandom_range(0, 9) != 0) ? upc[9] : !upc[9];
            used = model_sat(upc) && ($urandom_range(0, 3) != 0);
            step($urandom_range(0, 1), lp, uv, upc, tk, used);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule